// File: doc/BRIEF.md
# Multi-Channel PWM Timer Unit

This block holds several identical 16-bit timer channels behind one word-addressed register bus. Each channel divides the system clock by a selectable power of four, counts the divided ticks, compares the count against a pair of period and duty registers, and drives one pulse-width-modulated output pin. A single run-control register, placed below the channel banks, holds one bit per channel so software can start or stop any group of channels with one write.

In PWM use, software selects clear-on-compare-B in the control register, so compare B sets the period. It then writes the duty point to compare A, picks PWM mode and the low-then-high output pattern, and sets the channel's run bit. Compare values written while a channel runs are held in a buffer and applied only when the counter next clears, so a mid-period update never produces a malformed pulse.

Top module: `pwm_timer_unit`

## Requirements
- R1: Channel n's bank starts at byte address 0x40 + n*0x40, registers sit on a 4-byte stride (control 0x00, mode 0x04, output control 0x08, interrupt enable 0x0C, status 0x10, counter 0x14, compare A 0x18, B 0x1C, C 0x20, D 0x24), a read returns the stored value on bus_rdata one clock after bus_rd, and a read of any misaligned, unused or out-of-range address returns 0.
- R2: The run register at byte address 0x000 holds one bit per channel (bit n runs channel n when 1) and reads back the bits last written, upper bits zero.
- R3: Control bits [1:0] select the count divider: 0 gives one tick per clock, 1 one per 4, 2 one per 16, 3 one per 64; the divider restarts from zero each time a channel starts.
- R4: While running, the counter advances by one on each divided tick and changes at no other time except a bus write to it.
- R5: While a channel's run bit is 0 its counter and its output pin hold their values; the counter can be written and read back while stopped.
- R6: With control bits [6:5] = 2'b10 (value 0x0040), a tick at which the counter equals compare B returns it to 0, giving a period of B+1 ticks.
- R7: With mode bits [3:0] = 2 and output-control bits [3:0] = 2, the pin is low for counts below A and high from A through B; if A >= B it is low the whole period, if A = 0 it is high the whole period; in any other mode a running channel drives 0.
- R8: Status bit 0 is set by a compare A match tick and bit 1 by a compare B match tick; each stays set until a write puts 0 in that bit, and a 1 written leaves it unchanged.
- R9: A compare A or B write reads back at once but is applied to the comparison only at the next counter clear (or immediately while stopped).
- R10: Each channel runs, counts and drives its pin only according to its own run bit and registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_rd |
| pwm_out | output | NUM_CH | One PWM pin per channel |

## Verification
The bench builds the unit with three channels and the default 10-bit address, which leaves the fourth channel slot of the map unpopulated, so writes and reads there show the out-of-range decode returning zero. All four divider settings are exercised, with run windows sized so that each yields an exact whole number of ticks. PWM duty is measured at the pin over windows that span whole periods, which makes the expected high-cycle count independent of phase, including the degenerate A >= B and A = 0 cases and a buffered compare update taken mid-run.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int REG_W    = 16;
    localparam int IDX_W    = 4;
    localparam int NUM_REGS = 10;
    localparam int PRE_W    = 6;
    localparam int STAT_W   = 2;

    typedef enum logic [IDX_W-1:0] {
        RI_CTRL = 4'd0,
        RI_MODE = 4'd1,
        RI_OUTC = 4'd2,
        RI_IEN  = 4'd3,
        RI_STAT = 4'd4,
        RI_CNT  = 4'd5,
        RI_CMPA = 4'd6,
        RI_CMPB = 4'd7,
        RI_CMPC = 4'd8,
        RI_CMPD = 4'd9
    } reg_idx_e;

    // control field positions
    localparam int         CLR_LSB   = 5;
    localparam logic [1:0] CLR_ON_B  = 2'b10;
    localparam logic [3:0] MODE_PWM  = 4'h2;
    localparam logic [3:0] OUT_LO_HI = 4'h2;

    typedef struct packed {
        logic [REG_W-1:0] cmp_a;
        logic [REG_W-1:0] cmp_b;
    } cmp_pair_t;

    // last prescaler count before a tick
    function automatic logic [PRE_W-1:0] div_limit(input logic [1:0] sel);
        case (sel)
            2'd0:    return PRE_W'(0);
            2'd1:    return PRE_W'(3);
            2'd2:    return PRE_W'(15);
            default: return PRE_W'(63);
        endcase
    endfunction

    // pin level for a given count: high from A up to the period end
    function automatic logic pwm_level(input logic [REG_W-1:0] cnt, input cmp_pair_t cp);
        return (cp.cmp_a < cp.cmp_b) && (cnt >= cp.cmp_a);
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] div_sel,
    output logic       tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;

    assign lim  = div_limit(div_sel);
    assign tick = run && (pre_q >= lim);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q <= '0;
        end else if (pre_q >= lim) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rd_data,
    output logic [REG_W-1:0] cnt_o,
    output logic             tick_o,
    output logic             pwm_o
);
    logic [REG_W-1:0]  ctrl_q, mode_q, outc_q, ien_q, cmpc_q, cmpd_q;
    logic [REG_W-1:0]  buf_a_q, buf_b_q;
    logic [REG_W-1:0]  cnt_q;
    logic [STAT_W-1:0] stat_q, stat_nxt;
    cmp_pair_t         act_q;
    logic              pin_q;
    logic              tick, hit_a, hit_b, clr_hit, pwm_sel;

    pwm_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .div_sel (ctrl_q[1:0]),
        .tick    (tick)
    );

    assign hit_a   = tick && (cnt_q == act_q.cmp_a);
    assign hit_b   = tick && (cnt_q == act_q.cmp_b);
    assign clr_hit = hit_b && (ctrl_q[CLR_LSB+1:CLR_LSB] == CLR_ON_B);
    assign pwm_sel = (mode_q[3:0] == MODE_PWM) && (outc_q[3:0] == OUT_LO_HI);

    // plain storage registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            mode_q  <= '0;
            outc_q  <= '0;
            ien_q   <= '0;
            cmpc_q  <= '0;
            cmpd_q  <= '0;
            buf_a_q <= '0;
            buf_b_q <= '0;
        end else if (wr_en) begin
            case (reg_idx)
                RI_CTRL: ctrl_q  <= wdata;
                RI_MODE: mode_q  <= wdata;
                RI_OUTC: outc_q  <= wdata;
                RI_IEN:  ien_q   <= wdata;
                RI_CMPA: buf_a_q <= wdata;
                RI_CMPB: buf_b_q <= wdata;
                RI_CMPC: cmpc_q  <= wdata;
                RI_CMPD: cmpd_q  <= wdata;
                default: ;
            endcase
        end
    end

    // active compare pair: follows the buffer while stopped or at a clear
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
        end else if (!run || clr_hit) begin
            act_q <= '{cmp_a: buf_a_q, cmp_b: buf_b_q};
        end
    end

    // counter
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr_en && reg_idx == RI_CNT) begin
            cnt_q <= wdata;
        end else if (tick) begin
            cnt_q <= clr_hit ? '0 : cnt_q + 1'b1;
        end
    end

    // sticky match flags, cleared by writing zero
    always_comb begin
        stat_nxt = stat_q;
        if (wr_en && reg_idx == RI_STAT) begin
            stat_nxt = stat_q & wdata[STAT_W-1:0];
        end
        stat_nxt = stat_nxt | {hit_b, hit_a};
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_nxt;
    end

    // output pin: held while stopped
    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b0;
        end else if (run) begin
            pin_q <= pwm_sel ? pwm_level(cnt_q, act_q) : 1'b0;
        end
    end

    always_comb begin
        case (reg_idx)
            RI_CTRL: rd_data = ctrl_q;
            RI_MODE: rd_data = mode_q;
            RI_OUTC: rd_data = outc_q;
            RI_IEN:  rd_data = ien_q;
            RI_STAT: rd_data = REG_W'(stat_q);
            RI_CNT:  rd_data = cnt_q;
            RI_CMPA: rd_data = buf_a_q;
            RI_CMPB: rd_data = buf_b_q;
            RI_CMPC: rd_data = cmpc_q;
            RI_CMPD: rd_data = cmpd_q;
            default: rd_data = '0;
        endcase
    end

    assign cnt_o  = cnt_q;
    assign tick_o = tick;
    assign pwm_o  = pin_q;
endmodule

// File: rtl/pwm_timer_unit.sv
module pwm_timer_unit
    import pwm_timer_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int ADDR_W     = 10,
    parameter int START_ADDR = 0,
    parameter int CH_BASE    = 64,
    parameter int CH_STRIDE  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int OFF_W = $clog2(CH_STRIDE);
    localparam int SEL_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0]             rel;
    logic [SEL_W-1:0]              ch_sel;
    logic [IDX_W-1:0]              reg_idx;
    logic                          in_bank, reg_ok, map_ok, start_hit;
    logic [NUM_CH-1:0]             run_q;
    logic [NUM_CH-1:0]             ch_wr, ch_cnt_wr, ch_tick;
    logic [NUM_CH-1:0][REG_W-1:0]  ch_rd, ch_cnt;
    logic [REG_W-1:0]              rd_mux, rdata_q;

    // address decode
    assign rel       = bus_addr - ADDR_W'(CH_BASE);
    assign ch_sel    = rel[ADDR_W-1:OFF_W];
    assign reg_idx   = IDX_W'(rel[OFF_W-1:2]);
    assign in_bank   = (bus_addr >= ADDR_W'(CH_BASE)) && (ch_sel < SEL_W'(NUM_CH));
    assign reg_ok    = (rel[1:0] == 2'b00) && (rel[OFF_W-1:2] < (OFF_W-2)'(NUM_REGS));
    assign map_ok    = in_bank && reg_ok;
    assign start_hit = (bus_addr == ADDR_W'(START_ADDR));

    // shared run register
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (bus_wr && start_hit) begin
            run_q <= bus_wdata[NUM_CH-1:0];
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign ch_wr[g]     = bus_wr && map_ok && (ch_sel == SEL_W'(g));
        assign ch_cnt_wr[g] = ch_wr[g] && (reg_idx == RI_CNT);

        pwm_channel u_ch (
            .clk     (clk),
            .rst     (rst),
            .run     (run_q[g]),
            .wr_en   (ch_wr[g]),
            .reg_idx (reg_idx),
            .wdata   (bus_wdata),
            .rd_data (ch_rd[g]),
            .cnt_o   (ch_cnt[g]),
            .tick_o  (ch_tick[g]),
            .pwm_o   (pwm_out[g])
        );
    end

    always_comb begin
        rd_mux = '0;
        if (start_hit) begin
            rd_mux = REG_W'(run_q);
        end else if (map_ok) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_sel == SEL_W'(i)) rd_mux = ch_rd[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= rd_mux;
        end
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/pwm_timer_unit_sva.sv
module pwm_timer_unit_sva
    import pwm_timer_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int ADDR_W     = 10,
    parameter int START_ADDR = 0
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         bus_rd,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic [REG_W-1:0]             bus_rdata,
    input logic [NUM_CH-1:0]            run_q,
    input logic [NUM_CH-1:0]            ch_cnt_wr,
    input logic [NUM_CH-1:0]            ch_tick,
    input logic [NUM_CH-1:0][REG_W-1:0] ch_cnt,
    input logic [NUM_CH-1:0]            pwm_out
);
    // R2: run register read returns the run bits held at the read
    a_r2_run_readback: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(START_ADDR)) |=> bus_rdata == REG_W'($past(run_q)));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R3: no divided tick without the run bit
        a_r3_tick_needs_run: assert property (@(posedge clk) disable iff (rst)
            ch_tick[g] |-> run_q[g]);

        // R4: a tick moves the counter one step or to zero
        a_r4_tick_step: assert property (@(posedge clk) disable iff (rst)
            (ch_tick[g] && !ch_cnt_wr[g]) |=>
                (ch_cnt[g] == REG_W'($past(ch_cnt[g]) + 1'b1)) || (ch_cnt[g] == '0));

        // R4: no tick, no write, no change
        a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
            (run_q[g] && !ch_tick[g] && !ch_cnt_wr[g]) |=> $stable(ch_cnt[g]));

        // R5: stopped counter frozen unless written
        a_r5_cnt_frozen: assert property (@(posedge clk) disable iff (rst)
            (!run_q[g] && !ch_cnt_wr[g]) |=> $stable(ch_cnt[g]));

        // R5: stopped pin frozen
        a_r5_pin_frozen: assert property (@(posedge clk) disable iff (rst)
            !run_q[g] |=> $stable(pwm_out[g]));
    end
endmodule

bind pwm_timer_unit pwm_timer_unit_sva #(
    .NUM_CH     (NUM_CH),
    .ADDR_W     (ADDR_W),
    .START_ADDR (START_ADDR)
) u_sva (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .run_q     (run_q),
    .ch_cnt_wr (ch_cnt_wr),
    .ch_tick   (ch_tick),
    .ch_cnt    (ch_cnt),
    .pwm_out   (pwm_out)
);

// File: tb/pwm_timer_unit_bench.sv
module pwm_timer_unit_bench;
    localparam int NCH = 3;
    localparam int AW  = 10;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [15:0]    bus_wdata = '0;
    logic [15:0]    bus_rdata;
    logic [NCH-1:0] pwm_out;

    int n_chk = 0;
    int n_err = 0;
    logic [15:0] exp_q[$];
    string       req_q[$];
    logic        mon_pend = 1'b0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    pwm_timer_unit #(.NUM_CH(NCH), .ADDR_W(AW)) u_pwm_timer_unit (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    function automatic logic [AW-1:0] ra(input int ch, input int idx);
        return AW'(64 + ch * 64 + idx * 4);
    endfunction

    function automatic void chk(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endfunction

    task automatic bus_write(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // driver: push the expected item, then issue the read
    task automatic rd_chk(input logic [AW-1:0] a, input logic [15:0] e, input string req);
        @(negedge clk);
        exp_q.push_back(e);
        req_q.push_back(req);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic measure(input int ch, input int cycles, output int highs);
        highs = 0;
        repeat (cycles) begin
            @(negedge clk);
            highs += int'(pwm_out[ch]);
        end
    endtask

    // monitor: pop and compare when read data is due
    always @(posedge clk) mon_pend <= bus_rd;
    always @(negedge clk) begin
        if (mon_pend && exp_q.size() > 0) begin
            chk(int'(bus_rdata), int'(exp_q.pop_front()), req_q.pop_front());
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int h;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // reset state
        rd_chk(AW'(0), 16'h0000, "R2 reset");
        rd_chk(ra(0, 0), 16'h0000, "R1 reset ctrl");
        chk(int'(pwm_out), 0, "R7 reset pins");

        // R1 map and decode
        bus_write(ra(1, 8), 16'hA5C3);
        bus_write(ra(1, 9), 16'h1234);
        bus_write(ra(2, 3), 16'h00FF);
        bus_write(ra(1, 0), 16'h0041);
        bus_write(ra(3, 6), 16'hFFFF);
        rd_chk(ra(1, 8), 16'hA5C3, "R1 cmp C");
        rd_chk(ra(1, 9), 16'h1234, "R1 cmp D");
        rd_chk(ra(2, 3), 16'h00FF, "R1 ien");
        rd_chk(ra(1, 0), 16'h0041, "R1 ctrl");
        rd_chk(ra(1, 0) + AW'(2), 16'h0000, "R1 misaligned");
        rd_chk(ra(0, 10), 16'h0000, "R1 unused slot");
        rd_chk(ra(3, 6), 16'h0000, "R1 absent channel");
        rd_chk(ra(0, 6), 16'h0000, "R1 no alias");

        // R4/R5 counting and hold, divide by 1
        bus_write(ra(0, 0), 16'h0000);
        bus_write(ra(0, 5), 16'h0100);
        rd_chk(ra(0, 5), 16'h0100, "R5 write while stopped");
        bus_write(AW'(0), 16'h0001);
        repeat (19) @(negedge clk);
        bus_write(AW'(0), 16'h0000);
        rd_chk(ra(0, 5), 16'h0115, "R4 count 21 ticks");
        repeat (10) @(negedge clk);
        rd_chk(ra(0, 5), 16'h0115, "R5 count held");

        // R3 dividers
        bus_write(ra(0, 0), 16'h0001);
        bus_write(ra(0, 5), 16'h0000);
        bus_write(AW'(0), 16'h0001);
        repeat (38) @(negedge clk);
        bus_write(AW'(0), 16'h0000);
        rd_chk(ra(0, 5), 16'd10, "R3 div4");
        bus_write(ra(0, 0), 16'h0002);
        bus_write(ra(0, 5), 16'h0000);
        bus_write(AW'(0), 16'h0001);
        repeat (62) @(negedge clk);
        bus_write(AW'(0), 16'h0000);
        rd_chk(ra(0, 5), 16'd4, "R3 div16");
        bus_write(ra(0, 0), 16'h0003);
        bus_write(ra(0, 5), 16'h0000);
        bus_write(AW'(0), 16'h0001);
        repeat (126) @(negedge clk);
        bus_write(AW'(0), 16'h0000);
        rd_chk(ra(0, 5), 16'd2, "R3 div64");

        // R6/R7 PWM with clear on B
        bus_write(ra(0, 4), 16'h0000);
        bus_write(ra(0, 0), 16'h0040);
        bus_write(ra(0, 1), 16'h0002);
        bus_write(ra(0, 2), 16'h0002);
        bus_write(ra(0, 6), 16'd3);
        bus_write(ra(0, 7), 16'd9);
        bus_write(ra(0, 5), 16'h0000);
        bus_write(AW'(0), 16'h0001);
        repeat (30) @(negedge clk);
        measure(0, 100, h);
        chk(h, 70, "R7 duty A3 B9");
        bus_write(AW'(0), 16'h0000);
        rd_chk(ra(0, 5), 16'd2, "R6 wrap at B");
        rd_chk(ra(0, 4), 16'h0003, "R8 both flags");
        bus_write(ra(0, 4), 16'h0002);
        rd_chk(ra(0, 4), 16'h0002, "R8 clear A keep B");
        bus_write(ra(0, 4), 16'h0000);
        rd_chk(ra(0, 4), 16'h0000, "R8 clear B");

        // R3 in PWM, divide by 4
        bus_write(ra(0, 0), 16'h0041);
        bus_write(ra(0, 6), 16'd2);
        bus_write(ra(0, 7), 16'd4);
        bus_write(ra(0, 5), 16'h0000);
        bus_write(AW'(0), 16'h0001);
        repeat (30) @(negedge clk);
        measure(0, 80, h);
        chk(h, 48, "R3 pwm div4");
        bus_write(AW'(0), 16'h0000);

        // R9 buffered compare update while running
        bus_write(ra(0, 0), 16'h0040);
        bus_write(ra(0, 6), 16'd3);
        bus_write(ra(0, 7), 16'd9);
        bus_write(ra(0, 5), 16'h0000);
        bus_write(AW'(0), 16'h0001);
        repeat (20) @(negedge clk);
        bus_write(ra(0, 6), 16'd7);
        rd_chk(ra(0, 6), 16'd7, "R9 readback");
        repeat (30) @(negedge clk);
        measure(0, 100, h);
        chk(h, 30, "R9 new duty");
        bus_write(AW'(0), 16'h0000);

        // R7 degenerate compares
        bus_write(ra(0, 6), 16'd9);
        bus_write(AW'(0), 16'h0001);
        repeat (30) @(negedge clk);
        measure(0, 100, h);
        chk(h, 0, "R7 A equals B low");
        bus_write(AW'(0), 16'h0000);
        bus_write(ra(0, 6), 16'd0);
        bus_write(AW'(0), 16'h0001);
        repeat (30) @(negedge clk);
        measure(0, 100, h);
        chk(h, 100, "R7 A zero high");

        // R5 pin held when stopped
        bus_write(AW'(0), 16'h0000);
        repeat (20) @(negedge clk);
        chk(int'(pwm_out[0]), 1, "R5 pin held");

        // R7 other mode drives low
        bus_write(ra(0, 1), 16'h0000);
        bus_write(AW'(0), 16'h0001);
        repeat (5) @(negedge clk);
        chk(int'(pwm_out[0]), 0, "R7 non-pwm low");
        bus_write(AW'(0), 16'h0000);

        // R10 channel independence
        bus_write(ra(0, 5), 16'h0055);
        bus_write(ra(1, 0), 16'h0000);
        bus_write(ra(1, 5), 16'h0000);
        bus_write(AW'(0), 16'h0002);
        rd_chk(AW'(0), 16'h0002, "R2 run bits");
        repeat (20) @(negedge clk);
        bus_write(AW'(0), 16'h0000);
        rd_chk(ra(1, 5), 16'd24, "R10 ch1 counted");
        rd_chk(ra(0, 5), 16'h0055, "R10 ch0 untouched");
        chk(int'(pwm_out[2]), 0, "R10 ch2 pin");

        repeat (4) @(negedge clk);
        chk(exp_q.size(), 0, "R1 scoreboard drained");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule